// File: doc/BRIEF.md
# Serial-Chain Multichannel PWM Engine

This block drives a large bank of on/off loads, such as heater switches. It holds an 8-bit duty value for each channel and shifts one on/off bit per channel into an external chain of serial-in, parallel-out shift registers. Those registers have an output latch. Each frame shifts a full word of channel bits. A one-shift-clock strobe then moves the whole word onto the load switches at once. One PWM period is 2^DW frames, so the duty resolution is 1/2^DW.

A separate controller writes duty values through a simple memory-style write port, at any time. Writes land in a shadow bank. The shadow bank is copied into the active bank only when a new period begins. The frame loop therefore never pauses, and no period mixes old and new values.

A programmable frame length, counted in system clock cycles, sets the frame rate. The PWM period is 2^DW frame lengths. For example, about 2 Hz needs about 97,656 cycles per frame at 50 MHz with 256 frames.

Top module: `pwm_chain_engine`

## Requirements
- R1: Every frame produces exactly NCH rising edges of `ser_clk`. The bit for channel NCH-1 is shifted first and the bit for channel 0 is shifted last, so after NCH shifts channel k sits at stage k of the chain.
- R2: `ser_clk` is low for one system clock cycle and then high for one. `ser_dat` changes only while `ser_clk` is low, and it holds its value through the high phase.
- R3: Right after the high phase of the last bit, `ser_stb` is high for exactly two system clock cycles, which is one shift-clock period. `ser_clk` stays low while `ser_stb` is high.
- R4: Frames are numbered f = 0 .. 2^DW-1 within a period, and the first frame after reset is f = 0. A channel's bit in frame f is 1 exactly when f is less than its active duty value.
- R5: Over one period, a channel is on in exactly as many frames as its duty value. Duty 0 never turns on, and the maximum duty is on in every frame except the last.
- R6: A written duty value has no effect on the running period. It takes effect starting with the next frame 0, for every channel written before that frame starts.
- R7: Frames start every max(`frame_len`, 2*NCH+3) system clock cycles, so a frame never overlaps the previous one and no frame is skipped.
- R8: Reset clears every duty value in both banks to 0 and holds `ser_clk`, `ser_dat` and `ser_stb` low.
- R9: Writes never stretch or delay a frame; the frame interval stays as in R7 while writes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_len | input | PW | Requested frame length in clock cycles (prescaler) |
| wr_en | input | 1 | Duty write strobe |
| wr_addr | input | $clog2(NCH) | Channel to write |
| wr_data | input | DW | New duty value |
| ser_clk | output | 1 | Shift clock to the register chain |
| ser_dat | output | 1 | Serial channel bit, valid on the rising edge of ser_clk |
| ser_stb | output | 1 | Output-latch strobe for the chain |

## Verification
A frame that starts in cycle t puts its first shift-clock high phase in cycle t+2, its strobe in cycles t+2*NCH+1 and t+2*NCH+2, and the next frame start in cycle t+max(frame_len, 2*NCH+3). The bench models the external chain, which shifts on each rising edge of `ser_clk` and latches on the rising edge of `ser_stb`. It compares the latched word on the falling system-clock edge right after each strobe rises. Duty writes are driven only in the idle gap between a strobe and the next frame start. That places each write unambiguously before a known frame, and the bench's own shadow/active model applies it at the next frame 0.

// File: rtl/pwm_chain_pkg.sv
package pwm_chain_pkg;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_SHIFT,
    SH_LATCH
  } sh_state_t;

  // Channel is driven on in frame f when f lies below its duty value.
  function automatic logic chan_on(input logic [31:0] frame_no,
                                   input logic [31:0] duty);
    return frame_no < duty;
  endfunction

  // Effective frame length: the request, but never shorter than a full shift.
  function automatic logic [31:0] frame_cycles(input logic [31:0] req,
                                               input logic [31:0] floor_len);
    return (req < floor_len) ? floor_len : req;
  endfunction

endpackage

// File: rtl/duty_banks.sv
module duty_banks #(
  parameter int NCH = 256,
  parameter int DW  = 8,
  localparam int AW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          swap,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_duty
);

  logic [DW-1:0] shadow [NCH];
  logic [DW-1:0] active [NCH];

  // One shadow/active pair per channel; the active copy moves only on swap.
  for (genvar g = 0; g < NCH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[g] <= '0;
        active[g] <= '0;
      end else begin
        if (wr_en && (wr_addr == AW'(g))) shadow[g] <= wr_data;
        if (swap) active[g] <= shadow[g];
      end
    end
  end

  assign rd_duty = active[rd_addr];

endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int PW     = 20,
  parameter int DW     = 8,
  parameter int MINLEN = 515
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] frame_len,
  output logic          frame_go,
  output logic          period_go,
  output logic [DW-1:0] fidx
);
  import pwm_chain_pkg::*;

  logic [PW-1:0] cnt;
  logic [31:0]   lim;

  assign lim       = frame_cycles(32'(frame_len), 32'(MINLEN));
  assign frame_go  = (cnt == '0);
  assign period_go = frame_go && (fidx == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      fidx <= '1;
    end else begin
      if (32'(cnt) >= lim - 32'd1) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
      if (frame_go) fidx <= fidx + 1'b1;
    end
  end

endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int NCH = 256,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bit_in,
  output logic [CW-1:0] ch,
  output logic          ser_clk,
  output logic          ser_dat,
  output logic          ser_stb,
  output logic          busy
);
  import pwm_chain_pkg::*;

  sh_state_t     state;
  logic          ph;
  logic [CW-1:0] bidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      ph    <= 1'b0;
      bidx  <= '0;
    end else begin
      case (state)
        SH_IDLE: if (start) begin
          state <= SH_SHIFT;
          ph    <= 1'b0;
          bidx  <= CW'(NCH - 1);
        end
        SH_SHIFT: begin
          ph <= ~ph;
          if (ph) begin
            if (bidx == '0) state <= SH_LATCH;
            else            bidx  <= bidx - 1'b1;
          end
        end
        SH_LATCH: begin
          ph <= ~ph;
          if (ph) state <= SH_IDLE;
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  assign ch      = bidx;
  assign ser_clk = (state == SH_SHIFT) && ph;
  assign ser_dat = (state == SH_SHIFT) && bit_in;
  assign ser_stb = (state == SH_LATCH);
  assign busy    = (state != SH_IDLE);

endmodule

// File: rtl/pwm_chain_engine.sv
module pwm_chain_engine #(
  parameter int NCH = 256,
  parameter int DW  = 8,
  parameter int PW  = 20,
  localparam int CW     = $clog2(NCH),
  localparam int MINLEN = 2 * NCH + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] frame_len,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          ser_clk,
  output logic          ser_dat,
  output logic          ser_stb
);
  import pwm_chain_pkg::*;

  // Named internal events for the checker.
  logic          frame_go;
  logic          period_go;
  logic          shift_busy;
  logic [DW-1:0] fidx;
  logic [CW-1:0] ch_sel;
  logic [DW-1:0] ch_duty;
  logic          ch_bit;

  frame_timer #(.PW(PW), .DW(DW), .MINLEN(MINLEN)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_len (frame_len),
    .frame_go  (frame_go),
    .period_go (period_go),
    .fidx      (fidx)
  );

  duty_banks #(.NCH(NCH), .DW(DW)) u_banks (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .swap    (period_go),
    .rd_addr (ch_sel),
    .rd_duty (ch_duty)
  );

  assign ch_bit = chan_on(32'(fidx), 32'(ch_duty));

  serial_shifter #(.NCH(NCH)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (frame_go),
    .bit_in  (ch_bit),
    .ch      (ch_sel),
    .ser_clk (ser_clk),
    .ser_dat (ser_dat),
    .ser_stb (ser_stb),
    .busy    (shift_busy)
  );

endmodule

// File: rtl/pwm_chain_chk.sv
module pwm_chain_chk #(
  parameter int NCH    = 256,
  parameter int MINLEN = 515
) (
  input logic clk,
  input logic rst_n,
  input logic ser_clk,
  input logic ser_dat,
  input logic ser_stb,
  input logic frame_go,
  input logic shift_busy
);

  logic        sck_q;
  logic [31:0] edge_cnt;
  logic [31:0] gap;
  logic        seen_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      edge_cnt <= '0;
      gap      <= '0;
      seen_go  <= 1'b0;
    end else begin
      sck_q <= ser_clk;
      if (ser_stb)               edge_cnt <= '0;
      else if (ser_clk && !sck_q) edge_cnt <= edge_cnt + 1;
      if (frame_go) begin
        gap     <= 32'd1;
        seen_go <= 1'b1;
      end else if (gap != 32'hFFFF_FFFF) begin
        gap <= gap + 1;
      end
    end
  end

  // R1
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_stb) |-> (edge_cnt == 32'(NCH)));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_dat));

  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_stb) |=> ser_stb ##1 !ser_stb);

  // R3
  strobe_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stb |-> !ser_clk);

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |-> !shift_busy);

  // R7
  frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && seen_go) |-> (gap >= 32'(MINLEN)));

endmodule

bind pwm_chain_engine pwm_chain_chk #(.NCH(NCH), .MINLEN(MINLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ser_clk    (ser_clk),
  .ser_dat    (ser_dat),
  .ser_stb    (ser_stb),
  .frame_go   (frame_go),
  .shift_busy (shift_busy)
);

// File: tb/pwm_chain_engine_test.sv
module pwm_chain_engine_test;
  localparam int NCH    = 8;
  localparam int DW     = 4;
  localparam int PW     = 8;
  localparam int NFRAME = 1 << DW;
  localparam int DMAX   = NFRAME - 1;

  // Each row packs one duty per channel, channel 0 in the low nibble.
  localparam logic [31:0] ROWS [6] = '{
    32'h0000_0000, 32'h7654_3210, 32'hFFFF_FFFF,
    32'h1F08_3C0A, 32'h8421_0F5A, 32'h0000_000F
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] frame_len;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic          ser_clk, ser_dat, ser_stb;

  always #10 clk = ~clk;

  pwm_chain_engine #(.NCH(NCH), .DW(DW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .frame_len(frame_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model of the external chain: shift on ser_clk rise, latch on ser_stb rise.
  logic [NCH-1:0] chain_sr = '0;
  logic [NCH-1:0] latched  = '0;
  int             nstb     = 0;
  always @(posedge ser_clk) chain_sr <= {chain_sr[NCH-2:0], ser_dat};
  always @(posedge ser_stb) begin
    latched <= chain_sr;
    nstb    <= nstb + 1;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int exp_shadow [NCH];
  int exp_active [NCH];
  int on_cnt     [NCH];
  int  exp_len   = 40;
  int  skip_gap  = 0;
  int  last_f    = -1;
  int  seen      = 0;
  int  rises     = 0;
  int  stb_run   = 0;
  int  last_rise = -1;
  bit  p_sck = 0, p_dat = 0, p_stb = 0;
  event frame_checked;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk && !p_sck) begin
        check(ser_dat == p_dat, "R2 data held across rise", ser_dat, p_dat);
        rises++;
      end
      if (ser_stb) begin
        if (ser_clk) check(0, "R3 clock low in strobe", 1, 0);
        stb_run++;
      end
      if (!ser_stb && p_stb) begin
        check(stb_run == 2, "R3 strobe width", stb_run, 2);
        stb_run = 0;
      end
      if (ser_stb && !p_stb) begin
        check(p_sck, "R3 strobe follows last rise", p_sck, 1);
        check(rises == NCH, "R1 edges per frame", rises, NCH);
        rises = 0;
        if (last_rise >= 0 && skip_gap == 0)
          check(cyc - last_rise == exp_len, "R7 R9 frame interval", cyc - last_rise, exp_len);
        if (skip_gap > 0) skip_gap--;
        last_rise = cyc;
      end
      if (nstb != seen) begin
        int f;
        logic [NCH-1:0] want;
        seen = nstb;
        f = (seen - 1) % NFRAME;
        if (f == 0) begin
          for (int c = 0; c < NCH; c++) begin
            exp_active[c] = exp_shadow[c];
            on_cnt[c] = 0;
          end
        end
        for (int c = 0; c < NCH; c++) want[c] = (f < exp_active[c]);
        if (seen <= NFRAME)
          check(latched == want, "R8 R4 first period", latched, want);
        else
          check(latched == want, "R4 R6 frame word", latched, want);
        for (int c = 0; c < NCH; c++) on_cnt[c] += int'(latched[c]);
        if (f == NFRAME - 1)
          for (int c = 0; c < NCH; c++)
            check(on_cnt[c] == exp_active[c], "R5 on-frames per period", on_cnt[c], exp_active[c]);
        last_f = f;
        -> frame_checked;
      end
    end
    p_sck = ser_clk;
    p_dat = ser_dat;
    p_stb = ser_stb;
  end

  task automatic wait_frame(input int f);
    do @(frame_checked); while (last_f != f);
  endtask

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary_and_end();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      exp_shadow[c] = 0;
      exp_active[c] = 0;
      on_cnt[c]     = 0;
    end
    rst_n = 1'b0; frame_len = 8'd40; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R8: outputs quiet under reset
    check({ser_clk, ser_dat, ser_stb} == 3'b000, "R8 outputs in reset",
          {ser_clk, ser_dat, ser_stb}, 0);
    rst_n = 1'b1;

    // Table walk: each row written mid-period (after frame 5) -> R6 / R9.
    for (int r = 0; r < 6; r++) begin
      wait_frame(5);
      for (int c = 0; c < NCH; c++) begin
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 3'(c);
        wr_data = ROWS[r][4*c +: 4];
        exp_shadow[c] = int'(ROWS[r][4*c +: 4]);
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
    wait_frame(NFRAME - 1);
    wait_frame(NFRAME - 1);

    // R5: duty 0 and max duty on one period.
    wait_frame(5);
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 3'(c);
      wr_data = (c % 2 == 0) ? 4'(DMAX) : 4'd0;
      exp_shadow[c] = (c % 2 == 0) ? DMAX : 0;
    end
    @(negedge clk);
    wr_en = 1'b0;
    wait_frame(NFRAME - 1);
    wait_frame(NFRAME - 1);

    // R7: request below the minimum is clamped to 2*NCH+3.
    @(negedge clk);
    frame_len = 8'd5; exp_len = 2 * NCH + 3; skip_gap = 2;
    repeat (6) wait_frame((last_f + 1) % NFRAME);
    // R7: request above the minimum is used as given.
    @(negedge clk);
    frame_len = 8'd25; exp_len = 25; skip_gap = 2;
    repeat (6) wait_frame((last_f + 1) % NFRAME);

    summary_and_end();
  end

endmodule